// File: doc/BRIEF.md
# Backup Power Transfer Controller

This block is the digital decision logic of a unit that moves a load from the utility line onto a battery-fed inverter and back. Its inputs are comparator results that have already been digitized: the line is below its drop level, the line is above its higher return level, and the battery is under its warning level, above its warning-clear level, under its shutdown level or above its recovery level. It also takes an operator reset button, an arm signal that says the protected supply is present, and a safety interlock. A periodic tick, nominally 1 ms, sets the time base for every delay.

The controller drives the inverter/transfer-relay enable, a line-failure warning to the host processor, and four indicators: standby, on battery, low battery and offline. Both transfer directions wait a programmable number of ticks. Once on battery the unit stays there for a minimum dwell. A battery that falls too far forces the unit off the inverter into a latched offline state. The unit leaves that state only when the battery has recovered and the operator presses reset. Every asynchronous input passes through a two-flop synchronizer.

Top module: `bkup_xfer_ctrl`

## Requirements
- R1: After reset the unit is offline: `ind_offline`=1, `inverter_en`=0, `ind_standby`=0, `ind_on_batt`=0, `ac_fail`=0, `ind_low_batt`=0.
- R2: The unit leaves offline only when `batt_recovered` and `reset_btn` are both high. It then goes to standby. Pressing reset while the battery has not recovered leaves it offline.
- R3: While offline, a line failure (`line_low`=1) never enables the inverter.
- R4: From standby, a failed line (`line_low`=1) raises `inverter_en` after XFER_TICKS ticks. If `line_low` drops before that time, the transfer is abandoned and the unit stays in standby.
- R5: No transfer to battery occurs unless `psu_armed`=1 and `interlock_ok`=1.
- R6: Once `inverter_en` rises, it stays high for at least DWELL_TICKS ticks. If the line is good (`line_ok`=1) during the dwell, `inverter_en` falls XFER_TICKS ticks after the dwell ends.
- R7: When the line is neither failed nor above the return level (`line_low`=0, `line_ok`=0), the unit stays on battery indefinitely.
- R8: On battery, `batt_dead`=1 turns the inverter off within a few cycles, whatever the line state, and the unit enters offline.
- R9: `ind_low_batt` sets on `batt_warn_low`=1 and clears only on `batt_warn_ok`=1. It has no effect on the transfer state or the inverter.
- R10: `ac_fail` sets when `line_low`=1 and clears only when `line_ok`=1. This happens in every state, including offline.
- R11: Exactly one of `ind_standby`, `ind_on_batt` and `ind_offline` is high at all times, and `ind_on_batt` equals `inverter_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle time-base pulse (nominal 1 ms) |
| line_low | input | 1 | Line below drop threshold (async) |
| line_ok | input | 1 | Line above return threshold (async) |
| batt_warn_low | input | 1 | Battery below warning threshold (async) |
| batt_warn_ok | input | 1 | Battery above warning-clear threshold (async) |
| batt_dead | input | 1 | Battery below shutdown threshold (async) |
| batt_recovered | input | 1 | Battery above recovery threshold (async) |
| reset_btn | input | 1 | Operator reset button (async) |
| psu_armed | input | 1 | Protected supply present (async) |
| interlock_ok | input | 1 | Safety interlock closed (async) |
| inverter_en | output | 1 | Transfer relay and inverter enable |
| ac_fail | output | 1 | Line-failure warning to processor |
| ind_standby | output | 1 | Standby indicator |
| ind_on_batt | output | 1 | On-battery indicator |
| ind_low_batt | output | 1 | Low-battery indicator |
| ind_offline | output | 1 | Offline indicator |

## Verification
The bench measures transfer and dwell times in ticks. A timer that is off by several ticks, or a return that skips the dwell, therefore shows up as an inverter edge outside the allowed window. It holds the line in the band between the two thresholds and checks that the unit stays on battery; a design that returns on the falling `line_low` instead of a rising `line_ok` would drop the load early. It also tries a line failure while offline, while disarmed and with the interlock open, and presses reset with an unrecovered battery; a design with a missing gate would switch the inverter on or leave offline. A shutdown with the line still failed must still turn the inverter off; a design that waits for the line would keep draining the battery.

// File: rtl/bkup_pkg.sv
// Package: shared types for the backup transfer controller.
// Assumes: all sensing flags are active high.
package bkup_pkg;

    typedef enum logic [2:0] {
        ST_OFFLINE  = 3'd0,
        ST_STANDBY  = 3'd1,
        ST_TO_BATT  = 3'd2,
        ST_ON_BATT  = 3'd3,
        ST_TO_LINE  = 3'd4
    } xfer_state_t;

    typedef struct packed {
        logic line_low;
        logic line_ok;
        logic warn_low;
        logic warn_ok;
        logic dead;
        logic recovered;
        logic rst_btn;
        logic armed;
        logic ilk;
    } sense_t;

endpackage

// File: rtl/bkup_sync.sv
// Module: two-flop synchronizer for a bundle of asynchronous flags.
// Assumes: each bit is a slowly changing level; no bus coherence is needed.
module bkup_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Two register stages per bit; both clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/bkup_tick_timer.sv
// Module: saturating tick counter with a run-time selectable limit.
// Assumes: clr is pulsed on every state change; limit is stable between clears.
module bkup_tick_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          reached
);
    logic [CW-1:0] cnt_q;

    // Count ticks up to the limit, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (clr)                   cnt_q <= '0;
        else if (tick && cnt_q < limit) cnt_q <= cnt_q + 1'b1;
    end

    assign reached = (cnt_q >= limit);

    // Once reached, the count holds until the next clear (R6 dwell holds).
    assert_reached_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reached && !clr && $stable(limit)) |=> reached);
endmodule

// File: rtl/bkup_xfer_fsm.sv
// Module: transfer state machine with transfer delays, dwell and latched offline.
// Assumes: inputs are already synchronized; tick is a single-cycle pulse.
module bkup_xfer_fsm
    import bkup_pkg::*;
#(
    parameter int XFER_TICKS  = 15,
    parameter int DWELL_TICKS = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line_low,
    input  logic line_ok,
    input  logic batt_dead,
    input  logic batt_recovered,
    input  logic reset_req,
    input  logic enable_ok,
    output logic inverter_en,
    output logic st_standby,
    output logic st_on_batt,
    output logic st_offline
);
    localparam int MAXT = (DWELL_TICKS > XFER_TICKS) ? DWELL_TICKS : XFER_TICKS;
    localparam int CW   = $clog2(MAXT + 1);
    localparam logic [CW-1:0] XFER_L  = CW'(XFER_TICKS);
    localparam logic [CW-1:0] DWELL_L = CW'(DWELL_TICKS);

    xfer_state_t state_q, state_d;
    logic        t_reached;
    logic [CW-1:0] t_limit;

    // The on-battery state uses the dwell limit; the delay states use the transfer limit.
    assign t_limit = (state_q == ST_ON_BATT) ? DWELL_L : XFER_L;

    bkup_tick_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state_d != state_q),
        .tick    (tick),
        .limit   (t_limit),
        .reached (t_reached)
    );

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFFLINE: if (batt_recovered && reset_req) state_d = ST_STANDBY;
            ST_STANDBY: if (line_low && enable_ok)      state_d = ST_TO_BATT;
            ST_TO_BATT: begin
                if (!line_low || !enable_ok) state_d = ST_STANDBY;
                else if (t_reached)          state_d = ST_ON_BATT;
            end
            ST_ON_BATT: begin
                if (batt_dead)                 state_d = ST_OFFLINE;
                else if (t_reached && line_ok) state_d = ST_TO_LINE;
            end
            ST_TO_LINE: begin
                if (batt_dead)      state_d = ST_OFFLINE;
                else if (line_low)  state_d = ST_ON_BATT;
                else if (t_reached) state_d = ST_STANDBY;
            end
            default: state_d = ST_OFFLINE;
        endcase
    end

    // State register; power-up lands in offline.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFFLINE;
        else        state_q <= state_d;
    end

    assign inverter_en = (state_q == ST_ON_BATT) || (state_q == ST_TO_LINE);
    assign st_on_batt  = inverter_en;
    assign st_offline  = (state_q == ST_OFFLINE);
    assign st_standby  = (state_q == ST_STANDBY) || (state_q == ST_TO_BATT);

    assert_ind_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({st_standby, st_on_batt, st_offline}));
    assert_offline_no_xfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFFLINE) |=> !inverter_en);
    assert_leave_offline_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_offline && !(batt_recovered && reset_req)) |=> st_offline);
    assert_inhibit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STANDBY && !enable_ok) |=> (state_q == ST_STANDBY));
    assert_dwell_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ON_BATT && !t_reached) |=> (state_q != ST_TO_LINE));
    assert_shutdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inverter_en && batt_dead) |=> (st_offline && !inverter_en));
endmodule

// File: rtl/bkup_xfer_ctrl.sv
// Module: top of the backup transfer controller: synchronizers, flag latches, FSM.
// Assumes: tick is a single-cycle pulse in the clk domain; other inputs are async.
module bkup_xfer_ctrl
    import bkup_pkg::*;
#(
    parameter int XFER_TICKS  = 15,
    parameter int DWELL_TICKS = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line_low,
    input  logic line_ok,
    input  logic batt_warn_low,
    input  logic batt_warn_ok,
    input  logic batt_dead,
    input  logic batt_recovered,
    input  logic reset_btn,
    input  logic psu_armed,
    input  logic interlock_ok,
    output logic inverter_en,
    output logic ac_fail,
    output logic ind_standby,
    output logic ind_on_batt,
    output logic ind_low_batt,
    output logic ind_offline
);
    sense_t raw, s;

    assign raw = '{line_low: line_low, line_ok: line_ok, warn_low: batt_warn_low,
                   warn_ok: batt_warn_ok, dead: batt_dead, recovered: batt_recovered,
                   rst_btn: reset_btn, armed: psu_armed, ilk: interlock_ok};

    bkup_sync #(.W($bits(sense_t))) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw),
        .q     (s)
    );

    // Line-failure flag with hysteresis between drop and return levels.
    always_ff @(posedge clk) begin
        if (!rst_n)          ac_fail <= 1'b0;
        else if (s.line_low) ac_fail <= 1'b1;
        else if (s.line_ok)  ac_fail <= 1'b0;
    end

    // Low-battery flag with hysteresis between warning and clear levels.
    always_ff @(posedge clk) begin
        if (!rst_n)          ind_low_batt <= 1'b0;
        else if (s.warn_low) ind_low_batt <= 1'b1;
        else if (s.warn_ok)  ind_low_batt <= 1'b0;
    end

    bkup_xfer_fsm #(.XFER_TICKS(XFER_TICKS), .DWELL_TICKS(DWELL_TICKS)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick           (tick),
        .line_low       (s.line_low),
        .line_ok        (s.line_ok),
        .batt_dead      (s.dead),
        .batt_recovered (s.recovered),
        .reset_req      (s.rst_btn),
        .enable_ok      (s.armed && s.ilk),
        .inverter_en    (inverter_en),
        .st_standby     (ind_standby),
        .st_on_batt     (ind_on_batt),
        .st_offline     (ind_offline)
    );

    assert_lowbatt_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ind_low_batt) |-> $past(s.warn_low));
    assert_lowbatt_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ind_low_batt) |-> $past(s.warn_ok));
    assert_acfail_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ac_fail) |-> $past(s.line_ok && !s.line_low));
endmodule

// File: tb/bkup_xfer_ctrl_test.sv
module bkup_xfer_ctrl_test;
    localparam int XT = 3;
    localparam int DT = 12;
    localparam int TDIV = 8;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
    logic line_low = 0, line_ok = 1, warn_low = 0, warn_ok = 1;
    logic dead = 0, recov = 1, rbtn = 0, armed = 1, ilk = 1;
    logic inverter_en, ac_fail, ind_standby, ind_on_batt, ind_low_batt, ind_offline;

    int checks = 0, errors = 0, tick_count = 0, cyc = 0;
    bit wd_hit = 0;

    always #2 clk = ~clk;

    bkup_xfer_ctrl #(.XFER_TICKS(XT), .DWELL_TICKS(DT)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .line_low(line_low), .line_ok(line_ok),
        .batt_warn_low(warn_low), .batt_warn_ok(warn_ok), .batt_dead(dead),
        .batt_recovered(recov), .reset_btn(rbtn), .psu_armed(armed), .interlock_ok(ilk),
        .inverter_en(inverter_en), .ac_fail(ac_fail), .ind_standby(ind_standby),
        .ind_on_batt(ind_on_batt), .ind_low_batt(ind_low_batt), .ind_offline(ind_offline));

    // Tick generator driven away from the active edge, and a tick counter.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        tick <= ((cyc % TDIV) == 0);
    end
    always @(posedge clk) if (tick) tick_count <= tick_count + 1;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_range(input string req, input string what, input int act,
                             input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Wait for inverter_en to reach a level; return ticks elapsed or -1 on timeout.
    task automatic wait_inv(input logic lvl, input int maxcyc, output int ticks);
        int t0 = tick_count;
        ticks = -1;
        for (int i = 0; i < maxcyc; i++) begin
            @(negedge clk);
            if (inverter_en === lvl) begin
                ticks = tick_count - t0;
                break;
            end
        end
    endtask

    task automatic go_standby();
        recov = 1; rbtn = 1; cycles(5); rbtn = 0; cycles(3);
    endtask

    task automatic t_reset();
        chk("R1", "offline", ind_offline, 1);
        chk("R1", "inverter", inverter_en, 0);
        chk("R1", "standby", ind_standby, 0);
        chk("R1", "on_batt", ind_on_batt, 0);
        chk("R1", "ac_fail", ac_fail, 0);
        chk("R1", "low_batt", ind_low_batt, 0);
    endtask

    task automatic t_leave_offline();
        recov = 0; rbtn = 1; cycles(6); rbtn = 0; cycles(3);
        chk("R2", "offline kept without recovery", ind_offline, 1);
        recov = 1; cycles(6);
        chk("R2", "offline kept without button", ind_offline, 1);
        go_standby();
        chk("R2", "standby after reset", ind_standby, 1);
        chk("R11", "onehot standby", ind_standby + ind_on_batt + ind_offline, 1);
    endtask

    task automatic t_offline_fail();
        line_low = 1; line_ok = 0; cycles(TDIV * (XT + 3));
        chk("R3", "no inverter while offline", inverter_en, 0);
        chk("R10", "ac_fail set while offline", ac_fail, 1);
        line_low = 0; cycles(6);
        chk("R10", "ac_fail holds in band", ac_fail, 1);
        line_ok = 1; cycles(6);
        chk("R10", "ac_fail clears on return level", ac_fail, 0);
    endtask

    task automatic t_inhibit();
        armed = 0; line_low = 1; line_ok = 0; cycles(TDIV * (XT + 3));
        chk("R5", "no transfer when disarmed", inverter_en, 0);
        armed = 1; ilk = 0; cycles(TDIV * (XT + 3));
        chk("R5", "no transfer with interlock open", inverter_en, 0);
        line_low = 0; line_ok = 1; ilk = 1; cycles(6);
    endtask

    task automatic t_abort();
        line_low = 1; line_ok = 0; cycles(TDIV * (XT - 1) - 4);
        line_low = 0; line_ok = 1; cycles(TDIV * (XT + 3));
        chk("R4", "short dip abandoned", inverter_en, 0);
        chk("R4", "still standby", ind_standby, 1);
    endtask

    task automatic t_transfer_dwell();
        int t;
        line_low = 1; line_ok = 0;
        wait_inv(1'b1, TDIV * (XT + 6), t);
        chk_range("R4", "ticks to battery", t, XT, XT + 1);
        chk("R11", "on_batt follows inverter", ind_on_batt, 1);
        line_low = 0; line_ok = 1;
        wait_inv(1'b0, TDIV * (DT + XT + 6), t);
        chk_range("R6", "ticks on battery", t, DT + XT, DT + XT + 1);
        chk("R6", "standby after return", ind_standby, 1);
    endtask

    task automatic t_band();
        int t;
        line_low = 1; line_ok = 0;
        wait_inv(1'b1, TDIV * (XT + 6), t);
        line_low = 0; line_ok = 0;
        cycles(TDIV * (DT + XT + 6));
        chk("R7", "stays on battery in band", inverter_en, 1);
        line_ok = 1;
        wait_inv(1'b0, TDIV * (XT + 4), t);
        chk_range("R7", "return after line_ok", t, XT - 1, XT + 1);
    endtask

    task automatic t_lowbatt();
        warn_low = 1; warn_ok = 0; cycles(6);
        chk("R9", "low_batt set", ind_low_batt, 1);
        warn_low = 0; cycles(6);
        chk("R9", "low_batt holds in band", ind_low_batt, 1);
        chk("R9", "no effect on state", ind_standby, 1);
        chk("R9", "no effect on inverter", inverter_en, 0);
        warn_ok = 1; cycles(6);
        chk("R9", "low_batt clears", ind_low_batt, 0);
    endtask

    task automatic t_shutdown();
        int t;
        line_low = 1; line_ok = 0;
        wait_inv(1'b1, TDIV * (XT + 6), t);
        recov = 0; dead = 1; cycles(5);
        chk("R8", "inverter off on dead battery", inverter_en, 0);
        chk("R8", "offline after shutdown", ind_offline, 1);
        dead = 0; rbtn = 1; cycles(6); rbtn = 0; cycles(3);
        chk("R2", "reset ignored without recovery", ind_offline, 1);
        chk("R3", "line still failed, no transfer", inverter_en, 0);
    endtask

    initial begin
        cycles(4); rst_n = 1; cycles(2);
        t_reset();
        t_leave_offline();
        t_offline_fail_wrapper();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic t_offline_fail_wrapper();
        // Return to offline is only through shutdown, so test offline paths first.
        go_standby_from_offline_first();
    endtask

    task automatic go_standby_from_offline_first();
        rst_n = 0; cycles(3); rst_n = 1; cycles(2);
        t_offline_fail();
        go_standby();
        t_inhibit();
        t_abort();
        t_transfer_dwell();
        t_band();
        t_lowbatt();
        t_shutdown();
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        wd_hit = 1;
        errors++; checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule